// File: doc/BRIEF.md
# Front-End Sample FIFO Occupancy Veto

This block keeps a running model of how full a front-end readout chip's 32-entry trigger-sample buffer is. A central trigger controller uses the model to hold back new triggers before that buffer can overflow. The chip itself is not visible to the block. Every trigger the block accepts adds three or six samples to the model, depending on the sample mode. A drain engine then removes one sample for each 140 clocks of the 32 MHz design clock while the model is not empty.

The busy output rises as soon as the modelled fill level reaches 26 samples. The block also keeps a minimum gap between accepted triggers, because the chip needs three clocks (short mode) or six clocks (long mode) to take in one trigger. A trigger that arrives while busy is high, or too soon after the previous accepted trigger, is dropped and counted. A sticky error flag records any accepted trigger that would have pushed the model past full.

Top module: `trig_fifo_veto`

## Requirements
- R1: After reset the occupancy, busy output, rejected-trigger count and overflow flag are all 0.
- R2: An accepted trigger raises the occupancy on the next clock edge, by 3 when long_mode_i is 0 and by 6 when long_mode_i is 1. The mode used is the one sampled with the trigger.
- R3: The drain timer counts only while the occupancy is nonzero. Once the occupancy leaves zero, it drops by one every 140 clock edges. The timer restarts after each decrement and is held at zero while the occupancy is zero.
- R4: veto_o is 1 exactly when the occupancy is 26 or more.
- R5: After an accepted trigger, the next trigger can be accepted no earlier than 3 edges later in short mode and 6 edges later in long mode.
- R6: A trigger seen while veto_o is 1, or inside the spacing window, has no effect on the occupancy. It increments rej_cnt_o by one, and the count saturates at its maximum.
- R7: When an accepted trigger and a drain fall on the same edge, both take effect: the occupancy changes by the added samples minus one.
- R8: The occupancy never leaves the range 0 to 32. An accepted trigger that would take it past 32 leaves it at 32 and sets ovf_err_o, which then stays 1.
- R9: A high err_clr_i clears ovf_err_o on the next edge, unless an overflow happens on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz design clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Raw trigger strobe, sampled each edge |
| long_mode_i | input | 1 | 0: 3 samples per trigger, 1: 6 samples per trigger |
| err_clr_i | input | 1 | Clears the sticky overflow flag |
| veto_o | output | 1 | Busy: occupancy at or above the veto level |
| occ_o | output | 6 | Modelled sample occupancy |
| rej_cnt_o | output | 16 | Saturating count of dropped triggers |
| ovf_err_o | output | 1 | Sticky overflow error |

## Verification
The occupancy, the rejected count and the overflow flag all change on the edge that samples the trigger or the clear input. veto_o follows the registered occupancy without any further delay. A drain lands exactly 140 edges after the edge on which the occupancy left zero, and every 140 edges after that. Each scenario drives its inputs on the falling edge and counts rising edges from the trigger edge. It reads the outputs on the falling edge just after the edge where the requirement places the change. Around the drain boundary it also checks the edge before, where the value must still be unchanged.

// File: rtl/trig_veto_pkg.sv
package trig_veto_pkg;
   typedef enum logic {
      SMP_SHORT = 1'b0,
      SMP_LONG  = 1'b1
   } smp_mode_e;

   function automatic int samples_for(smp_mode_e m, int short_n, int long_n);
      return (m == SMP_LONG) ? long_n : short_n;
   endfunction
endpackage

// File: rtl/tv_spacing_guard.sv
module tv_spacing_guard #(
   parameter int SHORT_GAP = 3,
   parameter int LONG_GAP  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic long_i,
   input  logic blocked_i,
   output logic accept_o,
   output logic reject_o
);
   import trig_veto_pkg::*;
   localparam int HW = (LONG_GAP > 2) ? $clog2(LONG_GAP) : 1;

   generate
      if (SHORT_GAP < 2 || LONG_GAP < SHORT_GAP) begin : g_bad_gap
         $error("spacing guard: gaps must satisfy 2 <= SHORT_GAP <= LONG_GAP");
      end
   endgenerate

   logic [HW-1:0] hold_q;
   logic          window;

   assign window   = (hold_q != '0);
   assign accept_o = trig_i & ~window & ~blocked_i;
   assign reject_o = trig_i & ~accept_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (accept_o) begin
         hold_q <= HW'(samples_for(smp_mode_e'(long_i), SHORT_GAP, LONG_GAP) - 1);
      end else if (window) begin
         hold_q <= hold_q - 1'b1;
      end
   end

   // R5: two accepts never fall on adjacent edges
   p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> !accept_o);
endmodule

// File: rtl/tv_drain_timer.sv
module tv_drain_timer #(
   parameter int DRAIN_CLKS = 140
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic drain_o
);
   localparam int TW = $clog2(DRAIN_CLKS);

   generate
      if (DRAIN_CLKS < 2) begin : g_bad_drain
         $error("drain timer: DRAIN_CLKS must be at least 2");
      end
   endgenerate

   logic [TW-1:0] tick_q;

   assign drain_o = active_i && (tick_q == TW'(DRAIN_CLKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !active_i || drain_o) begin
         tick_q <= '0;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   // R3: timer sits at zero whenever the model is empty
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> tick_q == '0);
endmodule

// File: rtl/tv_occupancy.sv
module tv_occupancy #(
   parameter int DEPTH      = 32,
   parameter int VETO_LEVEL = 26,
   parameter int SHORT_ADD  = 3,
   parameter int LONG_ADD   = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc_i,
   input  logic                         long_i,
   input  logic                         drain_i,
   input  logic                         err_clr_i,
   output logic [$clog2(DEPTH+1)-1:0]   occ_o,
   output logic                         veto_o,
   output logic                         ovf_o
);
   import trig_veto_pkg::*;
   localparam int OW = $clog2(DEPTH + 1);

   generate
      if (VETO_LEVEL < 1 || VETO_LEVEL > DEPTH) begin : g_bad_level
         $error("occupancy: VETO_LEVEL must lie in 1..DEPTH");
      end
      if (LONG_ADD > DEPTH || SHORT_ADD < 1) begin : g_bad_add
         $error("occupancy: sample adds must lie in 1..DEPTH");
      end
   endgenerate

   logic [OW-1:0] occ_q;
   logic [OW:0]   add_w;
   logic [OW:0]   sum_w;
   logic          over_w;
   logic          ovf_q;

   always_comb begin
      add_w  = acc_i ? (OW+1)'(samples_for(smp_mode_e'(long_i), SHORT_ADD, LONG_ADD)) : '0;
      sum_w  = {1'b0, occ_q} + add_w - {{OW{1'b0}}, drain_i};
      over_w = (sum_w > (OW+1)'(DEPTH));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         occ_q <= over_w ? OW'(DEPTH) : sum_w[OW-1:0];
         if (over_w)         ovf_q <= 1'b1;
         else if (err_clr_i) ovf_q <= 1'b0;
      end
   end

   assign occ_o  = occ_q;
   assign veto_o = (occ_q >= OW'(VETO_LEVEL));
   assign ovf_o  = ovf_q;

   // R8: model stays within the buffer depth
   p_occ_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OW'(DEPTH));
   // R6: without an accept the model never grows
   p_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_i |=> occ_q <= $past(occ_q));
   // R3: a drain only arrives while samples are held
   p_drain_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drain_i |-> occ_q != '0);
   // R8: error flag holds until cleared
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q && !err_clr_i |=> ovf_q);
endmodule

// File: rtl/tv_reject_counter.sv
module tv_reject_counter #(
   parameter int  CW       = 16,
   parameter bit  SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rej_i,
   output logic [CW-1:0] cnt_o
);
   logic [CW-1:0] cnt_q;
   logic          bump;

   generate
      if (SATURATE) begin : g_sat
         assign bump = rej_i && (cnt_q != '1);
      end else begin : g_wrap
         assign bump = rej_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (bump) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R6: the count only moves on a rejected trigger
   p_rej_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rej_i |=> $stable(cnt_q));
endmodule

// File: rtl/trig_fifo_veto.sv
module trig_fifo_veto #(
   parameter int DEPTH      = 32,
   parameter int VETO_LEVEL = 26,
   parameter int DRAIN_CLKS = 140,
   parameter int SHORT_SMP  = 3,
   parameter int LONG_SMP   = 6,
   parameter int REJ_W      = 16,
   parameter bit REJ_SAT    = 1'b1,
   localparam int OW        = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             long_mode_i,
   input  logic             err_clr_i,
   output logic             veto_o,
   output logic [OW-1:0]    occ_o,
   output logic [REJ_W-1:0] rej_cnt_o,
   output logic             ovf_err_o
);
   logic accept_w, reject_w, drain_w, veto_w;
   logic [OW-1:0] occ_w;

   tv_spacing_guard #(.SHORT_GAP(SHORT_SMP), .LONG_GAP(LONG_SMP)) u_guard (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .long_i(long_mode_i),
      .blocked_i(veto_w), .accept_o(accept_w), .reject_o(reject_w));

   tv_drain_timer #(.DRAIN_CLKS(DRAIN_CLKS)) u_drain (
      .clk(clk), .rst_n(rst_n), .active_i(occ_w != '0), .drain_o(drain_w));

   tv_occupancy #(.DEPTH(DEPTH), .VETO_LEVEL(VETO_LEVEL),
                  .SHORT_ADD(SHORT_SMP), .LONG_ADD(LONG_SMP)) u_occ (
      .clk(clk), .rst_n(rst_n), .acc_i(accept_w), .long_i(long_mode_i),
      .drain_i(drain_w), .err_clr_i(err_clr_i), .occ_o(occ_w),
      .veto_o(veto_w), .ovf_o(ovf_err_o));

   tv_reject_counter #(.CW(REJ_W), .SATURATE(REJ_SAT)) u_rej (
      .clk(clk), .rst_n(rst_n), .rej_i(reject_w), .cnt_o(rej_cnt_o));

   assign veto_o = veto_w;
   assign occ_o  = occ_w;

   // R4: no trigger gets through while busy is shown
   p_veto_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      veto_w && trig_i |-> reject_w);
endmodule

// File: tb/tb_trig_fifo_veto.sv
`timescale 1ns/1ps
module tb_trig_fifo_veto;
   localparam realtime CLK_PERIOD = 31.25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig = 1'b0, trig2 = 1'b0, long_mode = 1'b0, clr = 1'b0;
   logic veto, veto2, ovf, ovf2;
   logic [5:0] occ, occ2;
   logic [15:0] rej, rej2;
   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trig_fifo_veto dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .long_mode_i(long_mode),
      .err_clr_i(clr), .veto_o(veto), .occ_o(occ), .rej_cnt_o(rej),
      .ovf_err_o(ovf));

   // veto level equal to depth so the overflow path can be reached
   trig_fifo_veto #(.VETO_LEVEL(32)) dut_full (
      .clk(clk), .rst_n(rst_n), .trig_i(trig2), .long_mode_i(long_mode),
      .err_clr_i(clr), .veto_o(veto2), .occ_o(occ2), .rej_cnt_o(rej2),
      .ovf_err_o(ovf2));

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; trig = 1'b0; trig2 = 1'b0; clr = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
   endtask

   task automatic hold_trig(int n);
      trig = 1'b1; wait_n(n); trig = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 occ", occ, 0);
      check("R1 veto", veto, 0);
      check("R1 rej", rej, 0);
      check("R1 ovf", ovf, 0);
   endtask

   task automatic t_add_and_drain();
      do_reset(); long_mode = 1'b0;
      hold_trig(1);
      check("R2 short add", occ, 3);
      wait_n(139);
      check("R3 before first drain", occ, 3);
      wait_n(1);
      check("R3 first drain", occ, 2);
      wait_n(280);
      check("R3 drained empty", occ, 0);
      wait_n(300);
      check("R3 idle stays empty", occ, 0);
   endtask

   task automatic t_short_gap();
      do_reset(); long_mode = 1'b0;
      hold_trig(4);
      check("R5 short gap occ", occ, 6);
      check("R6 short gap rejects", rej, 2);
   endtask

   task automatic t_long_gap();
      do_reset(); long_mode = 1'b1;
      hold_trig(7);
      check("R2 long add / R5 long gap occ", occ, 12);
      check("R6 long gap rejects", rej, 5);
   endtask

   task automatic t_veto();
      do_reset(); long_mode = 1'b1;
      hold_trig(36);
      check("R4 veto raised", veto, 1);
      check("R6 veto keeps occ", occ, 30);
      check("R6 veto rejects", rej, 31);
      check("R8 no overflow below cap", ovf, 0);
      wait_n(525);
      check("R4 at level", occ, 26);
      check("R4 busy at level", veto, 1);
      wait_n(140);
      check("R4 below level occ", occ, 25);
      check("R4 released below level", veto, 0);
   endtask

   task automatic t_same_edge();
      do_reset(); long_mode = 1'b0;
      hold_trig(1);
      wait_n(139);
      hold_trig(1);
      check("R7 add with drain", occ, 5);
   endtask

   task automatic t_overflow();
      do_reset(); long_mode = 1'b1;
      trig2 = 1'b1; wait_n(31); trig2 = 1'b0;
      check("R8 capped occ", occ2, 32);
      check("R8 overflow flag", ovf2, 1);
      wait_n(5);
      check("R8 flag sticky", ovf2, 1);
      clr = 1'b1; wait_n(1); clr = 1'b0;
      check("R9 flag cleared", ovf2, 0);
   endtask

   initial begin
      t_reset();
      t_add_and_drain();
      t_short_gap();
      t_long_gap();
      t_veto();
      t_same_edge();
      t_overflow();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule